// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block monitors the two open-drain lines of an I2C bus from a system clock that runs much faster than the bus clock. No phase relation between the two clocks is assumed. Each raw line first passes through a two-flop synchronizer. It then enters a four-sample deglitch stage with hysteresis. Both lines use identical stages, so a change on SCL and a change on SDA reach the detection logic after the same number of cycles.

From the filtered levels and their one-cycle-old copies, the block produces single-cycle strobes for bus START and bus STOP. It also produces strobes for the rising and falling edges of the filtered SCL. A START that follows another START with no STOP in between gives the same strobe as any other START. A protocol engine downstream uses these strobes to frame transfers and to sample data bits.

Top module: `i2c_cond_detect`

## Requirements
- R1: A raw line change that stays stable appears on the matching filtered output (`scl_o`/`sda_o`) exactly 7 system clocks later: 2 synchronizer flops, 4 history samples with the newest at bit 0, and 1 filtered-level register. It does not appear after only 6 clocks.
- R2: A filtered level changes only when all four history samples agree on the opposite value. A mixed history holds the previous level; it is not resolved by majority.
- R3: SCL and SDA take the same path. Raw changes made in the same cycle on both lines appear on both filtered outputs in the same cycle.
- R4: `start_o` is high for exactly one cycle when the filtered SDA goes from 1 to 0 while the filtered SCL is 1 in both the current and the previous cycle.
- R5: `stop_o` is high for exactly one cycle when the filtered SDA goes from 0 to 1 while the filtered SCL is 1 in both the current and the previous cycle.
- R6: A START that arrives with no STOP since the previous START gives the same one-cycle `start_o` pulse.
- R7: A change of SDA while SCL is low gives neither `start_o` nor `stop_o`. A change of SDA in the same cycle as SCL also gives neither.
- R8: A raw pulse lasting fewer than four system clocks, on either line, changes no filtered level and gives no strobe. A pulse lasting exactly four clocks is accepted.
- R9: `scl_rise_o` and `scl_fall_o` are high for one cycle, in the cycle in which `scl_o` becomes 1 or 0 respectively.
- R10: The synchronous active-high reset sets every synchronizer flop, every history bit, every filtered level and every previous-value copy to 1. While reset is held, `scl_o` and `sda_o` read 1 and all strobes read 0. Releasing reset with both lines high gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw SCL line, asynchronous |
| sda_in | input | 1 | Raw SDA line, asynchronous |
| scl_o | output | 1 | Filtered SCL level |
| sda_o | output | 1 | Filtered SDA level |
| start_o | output | 1 | One-cycle START (or repeated START) strobe |
| stop_o | output | 1 | One-cycle STOP strobe |
| scl_rise_o | output | 1 | One-cycle strobe on a filtered SCL rising edge |
| scl_fall_o | output | 1 | One-cycle strobe on a filtered SCL falling edge |

## Verification
Every result of this block becomes visible 7 system clocks after a stable raw change. The filtered levels and all four strobes change together in that cycle, and the strobes return low one clock later. The bench drives inputs on a falling clock edge. It then checks that nothing has moved after 6 edges, checks the new levels and strobe values after the 7th edge, and checks that the strobes have cleared after the 8th edge. Glitch, hysteresis and reset tests count the strobes over a whole window, one sample per clock, so that a stray pulse in any cycle is caught.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  // Hysteresis: move only on a unanimous history, otherwise hold.
  function automatic logic hyst_next(input logic all_high, input logic all_low,
                                     input logic held);
    if (all_high)     return 1'b1;
    else if (all_low) return 1'b0;
    else              return held;
  endfunction

  // SDA falls while SCL has been high for two samples.
  function automatic logic bus_start(input logic scl_now, input logic scl_was,
                                     input logic sda_now, input logic sda_was);
    return scl_now & scl_was & sda_was & ~sda_now;
  endfunction

  // SDA rises while SCL has been high for two samples.
  function automatic logic bus_stop(input logic scl_now, input logic scl_was,
                                    input logic sda_now, input logic sda_was);
    return scl_now & scl_was & ~sda_was & sda_now;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_deglitch.sv
module i2c_deglitch
  import i2c_cond_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic level,
  output logic level_prev
);
  logic [HIST_W-1:0] hist_q;
  logic              level_q;
  logic              prev_q;
  logic              hist_all_hi;
  logic              hist_all_lo;

  assign hist_all_hi = &hist_q;
  assign hist_all_lo = ~|hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      hist_q  <= {hist_q[HIST_W-2:0], sample};
      level_q <= hyst_next(hist_all_hi, hist_all_lo, level_q);
      prev_q  <= level_q;
    end
  end

  assign level      = level_q;
  assign level_prev = prev_q;

  // R2
  level_unanimous_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(hist_q) == {HIST_W{level_q}}));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (level_q && prev_q && (hist_q == '1)));

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_W      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [NUM_LINES-1:0] raw_vec;
  logic [NUM_LINES-1:0] sync_vec;
  logic [NUM_LINES-1:0] filt_vec;
  logic [NUM_LINES-1:0] prev_vec;

  assign raw_vec[LINE_SCL] = scl_in;
  assign raw_vec[LINE_SDA] = sda_in;

  // One identical path per line keeps the relative delay of SCL and SDA.
  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_vec[ln]),
      .q   (sync_vec[ln])
    );
    i2c_deglitch #(.HIST_W(HIST_W)) u_filt (
      .clk        (clk),
      .rst        (rst),
      .sample     (sync_vec[ln]),
      .level      (filt_vec[ln]),
      .level_prev (prev_vec[ln])
    );
  end

  // Named internal events.
  logic ev_start, ev_stop, ev_rise, ev_fall;

  assign ev_start = bus_start(filt_vec[LINE_SCL], prev_vec[LINE_SCL],
                              filt_vec[LINE_SDA], prev_vec[LINE_SDA]);
  assign ev_stop  = bus_stop(filt_vec[LINE_SCL], prev_vec[LINE_SCL],
                             filt_vec[LINE_SDA], prev_vec[LINE_SDA]);
  assign ev_rise  = filt_vec[LINE_SCL] & ~prev_vec[LINE_SCL];
  assign ev_fall  = ~filt_vec[LINE_SCL] & prev_vec[LINE_SCL];

  assign scl_o      = filt_vec[LINE_SCL];
  assign sda_o      = filt_vec[LINE_SDA];
  assign start_o    = ev_start;
  assign stop_o     = ev_stop;
  assign scl_rise_o = ev_rise;
  assign scl_fall_o = ev_fall;

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R5
  stop_single_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);

  // R4
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));

  // R7
  start_needs_scl_chk: assert property (@(posedge clk) disable iff (rst)
    (start_o || stop_o) |-> (scl_o && !scl_rise_o && !scl_fall_o));

  // R9
  rise_level_chk: assert property (@(posedge clk) disable iff (rst)
    scl_rise_o |=> (scl_o && !scl_rise_o));

  // R9
  fall_level_chk: assert property (@(posedge clk) disable iff (rst)
    scl_fall_o |=> (!scl_o && !scl_fall_o));

endmodule

// File: tb/i2c_cond_detect_test.sv
module i2c_cond_detect_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic scl_o, sda_o, start_o, stop_o, scl_rise_o, scl_fall_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_cond_detect uut (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall_o)
  );

  localparam int LAT = 7;  // sync 2 + history 4 + level 1

  // Stimulus vectors {scl, sda}; expected strobes are derived by the bench model.
  localparam int NV = 12;
  localparam logic [1:0] VEC [NV] = '{
    2'b10,  // start
    2'b00,  // scl fall
    2'b01,  // sda change with scl low
    2'b11,  // scl rise
    2'b10,  // repeated start
    2'b00,  // scl fall
    2'b10,  // scl rise with sda low
    2'b11,  // stop
    2'b00,  // both fall together
    2'b11,  // both rise together
    2'b10,  // start
    2'b11   // stop
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {scl,sda,start,stop,rise,fall} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {scl_o, sda_o, start_o, stop_o, scl_rise_o, scl_fall_o};
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count strobes and level changes across a window, sampling once per cycle.
  task automatic watch(input int n, output int n_start, output int n_stop,
                       output int n_rise, output int n_fall, output int sda_low);
    n_start = 0; n_stop = 0; n_rise = 0; n_fall = 0; sda_low = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_start += int'(start_o);
      n_stop  += int'(stop_o);
      n_rise  += int'(scl_rise_o);
      n_fall  += int'(scl_fall_o);
      sda_low += int'(!sda_o);
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic scl_m, sda_m;
    int a, b, c, d, e;

    // R10: state during reset
    step(3);
    check("R10 in reset", outs(), 6'b110000);
    // R10: release with idle lines gives no strobe
    rst = 1'b0;
    watch(12, a, b, c, d, e);
    check_int("R10 no strobe after release", a + b + c + d + e, 0);

    // Vector walk with independent model
    scl_m = 1'b1; sda_m = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic ns, nd, es, ep, er, ef;
      ns = VEC[v][1]; nd = VEC[v][0];
      es = scl_m & ns & sda_m & ~nd;   // R4, R6
      ep = scl_m & ns & ~sda_m & nd;   // R5
      er = ~scl_m & ns;                // R9
      ef = scl_m & ~ns;                // R9
      scl_in = ns; sda_in = nd;
      step(LAT - 1);
      check($sformatf("R1 vec%0d before latency", v), outs(), {scl_m, sda_m, 4'b0000});
      step(1);
      check($sformatf("R1 R3 R4 R5 R6 R7 R9 vec%0d at latency", v), outs(),
            {ns, nd, es, ep, er, ef});
      step(1);
      check($sformatf("R4 R5 R9 vec%0d strobes cleared", v), outs(), {ns, nd, 4'b0000});
      step(4);
      scl_m = ns; sda_m = nd;
    end

    // Now scl=1, sda=1. R8: three-cycle SDA glitch with SCL high
    sda_in = 1'b0; step(3); sda_in = 1'b1;
    watch(20, a, b, c, d, e);
    check_int("R8 sda 3-cycle glitch start", a, 0);
    check_int("R8 sda 3-cycle glitch sda_o low", e, 0);

    // R8 boundary: four-cycle SDA pulse is accepted (start then stop)
    sda_in = 1'b0; step(4); sda_in = 1'b1;
    watch(20, a, b, c, d, e);
    check_int("R8 sda 4-cycle pulse start", a, 1);
    check_int("R8 sda 4-cycle pulse stop", b, 1);
    check_int("R8 sda 4-cycle pulse low cycles", e, 4);

    // R8: three-cycle SCL glitch
    scl_in = 1'b0; step(3); scl_in = 1'b1;
    watch(20, a, b, c, d, e);
    check_int("R8 scl 3-cycle glitch edges", c + d, 0);

    // R2: mixed SDA history with SCL low holds level (no majority)
    scl_in = 1'b0; step(12);
    for (int k = 0; k < 4; k++) begin
      sda_in = 1'b0; step(3);
      sda_in = 1'b1; step(1);
    end
    watch(12, a, b, c, d, e);
    check_int("R2 mixed history keeps sda high", e, 0);
    check_int("R2 R7 mixed history strobes", a + b, 0);

    // R10: reset from a low bus forces all levels high
    sda_in = 1'b0; step(12);
    check("R10 bus low before reset", outs(), 6'b000000);
    rst = 1'b1; step(1);
    check("R10 reset forces idle", outs(), 6'b110000);
    scl_in = 1'b1; sda_in = 1'b1; step(3);
    rst = 1'b0;
    watch(15, a, b, c, d, e);
    check_int("R10 release from forced idle", a + b + c + d + e, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule